// File: doc/BRIEF.md
# Reset and Power-On Configuration Sequencer

This block produces and tracks the system reset of a single bus agent. After its own asynchronous reset it keeps the bus reset asserted and waits for power-good. Only once power-good is seen does it count a programmable number of bus clocks before it releases reset. A warm reset, requested by a single-cycle strobe while the agent runs, holds reset for the same number of clocks without waiting on power-good. If power-good drops at any time, the sequencer returns to waiting, and the count starts again from zero once power-good comes back.

On the clock edge where reset is released, the sequencer captures a configuration word from the strap lines. One cycle later it gives a single-clock start pulse, which tells the agent to fetch from its reset vector. One strap bit requests that the agent's outputs stay floated. When that bit is captured high, the start pulse is not issued and the output-enable gate stays low. Whenever reset is entered from the running state, the block emits a one-cycle invalidate-all pulse for the agent's caches. There is no writeback request. The output-enable gate falls one clock after reset goes high.

Top module: `rstseq_top`

## Requirements
- R1: While and right after `arst_n` is low, `bus_rst_o`=1, `drive_en_o`=0, `start_o`=0, `inval_o`=0 and `cfg_o`=0.
- R2: In the cold-wait state `bus_rst_o` stays 1 for as long as `pwr_good` is 0, however many cycles that lasts.
- R3: Counting from the edge that first samples `pwr_good`=1 (cold) or `warm_req`=1 in the running state (warm), `bus_rst_o` is 1 for exactly HOLD_CYC cycles and then goes to 0.
- R4: `pwr_good` sampled 0 during a hold or while running forces `bus_rst_o` to 1 on the next cycle. The next hold then counts a full HOLD_CYC cycles from the edge where `pwr_good` is again sampled 1.
- R5: `warm_req` asserted while a hold is in progress has no effect: that hold still lasts exactly HOLD_CYC cycles.
- R6: `drive_en_o` is 0 in the cycle after any cycle with `bus_rst_o`=1. It becomes 1 one cycle after reset release when strap bit TRI_BIT (bit 0) was captured as 0, and it stays 0 when that bit was captured as 1.
- R7: `cfg_o` takes the value of `strap_i` sampled on the release edge, which is the first cycle with `bus_rst_o`=0, and holds that value until the next release.
- R8: `start_o` is a one-cycle pulse in the cycle after release, when `cfg_o` bit 0 is 0. It is not issued when that bit is 1.
- R9: `inval_o` is a one-cycle pulse in the first cycle of a reset entered from the running state. It does not occur in a cold hold that follows a cold wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| arst_n | input | 1 | Asynchronous active-low block reset |
| pwr_good | input | 1 | Power-good level |
| warm_req | input | 1 | Warm reset request strobe |
| strap_i | input | CFG_W | Bus lines sampled as configuration |
| bus_rst_o | output | 1 | Reset level driven to the agent, active high |
| drive_en_o | output | 1 | Gate that allows the agent's bus outputs |
| cfg_o | output | CFG_W | Configuration word captured at release |
| start_o | output | 1 | One-cycle pulse to begin execution |
| inval_o | output | 1 | One-cycle cache invalidate-all pulse |

## Verification
The hardest case to reach from the ports is a power-good dropout at every possible position inside a hold, including the final cycle, where the count has already finished but release has not yet happened. The bench runs a sweep in which power-good is pulled low after k observed hold cycles, for every k from 1 to HOLD_CYC. It then restores power-good and checks that the next hold is a full, fresh count. A second sweep issues warm resets with every strap value. Every odd iteration also pokes `warm_req` in the middle of the hold, so that the floated-output and ignored-request cases are covered across all configurations.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [1:0] {
    SEQ_WAIT_PG = 2'd0,
    SEQ_HOLD    = 2'd1,
    SEQ_RUN     = 2'd2
  } seq_state_e;
endpackage

// File: rtl/rstseq_hold_timer.sv
module rstseq_hold_timer #(
  parameter int HOLD_CYC = 250000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign done = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)             cnt_d = '0;
    else if (en && !done) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       pwr_good,
  input  logic       warm_req,
  input  logic       hold_done,
  output seq_state_e state_o,
  output logic       release_ev,
  output logic       enter_rst_ev
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_WAIT_PG: if (pwr_good) state_d = SEQ_HOLD;
      SEQ_HOLD: begin
        if (!pwr_good)      state_d = SEQ_WAIT_PG;
        else if (hold_done) state_d = SEQ_RUN;
      end
      SEQ_RUN: begin
        if (!pwr_good)     state_d = SEQ_WAIT_PG;
        else if (warm_req) state_d = SEQ_HOLD;
      end
      default: state_d = SEQ_WAIT_PG;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) state_q <= SEQ_WAIT_PG;
    else         state_q <= state_d;
  end

  assign state_o      = state_q;
  assign release_ev   = (state_q == SEQ_HOLD) && (state_d == SEQ_RUN);
  assign enter_rst_ev = (state_q == SEQ_RUN) && (state_d != SEQ_RUN);
endmodule

// File: rtl/rstseq_cfg_latch.sv
module rstseq_cfg_latch #(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             capture,
  input  logic [CFG_W-1:0] strap,
  output logic [CFG_W-1:0] cfg
);
  for (genvar b = 0; b < CFG_W; b++) begin : g_bit
    logic bit_q, bit_d;
    always_comb bit_d = capture ? strap[b] : bit_q;
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) bit_q <= 1'b0;
      else         bit_q <= bit_d;
    end
    assign cfg[b] = bit_q;
  end
endmodule

// File: rtl/rstseq_out_stage.sv
module rstseq_out_stage #(
  parameter int CFG_W   = 8,
  parameter int TRI_BIT = 0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             running,
  input  logic             release_ev,
  input  logic             enter_rst_ev,
  input  logic [CFG_W-1:0] cfg,
  output logic             drive_en,
  output logic             start,
  output logic             inval
);
  logic floated;
  logic rel_q, rel_d;
  logic drv_q, drv_d;
  logic start_q, start_d;
  logic inval_q, inval_d;

  assign floated = cfg[TRI_BIT];

  always_comb begin
    rel_d   = release_ev;
    drv_d   = running && !floated;
    start_d = rel_q && !floated;
    inval_d = enter_rst_ev;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rel_q   <= 1'b0;
      drv_q   <= 1'b0;
      start_q <= 1'b0;
      inval_q <= 1'b0;
    end else begin
      rel_q   <= rel_d;
      drv_q   <= drv_d;
      start_q <= start_d;
      inval_q <= inval_d;
    end
  end

  assign drive_en = drv_q;
  assign start    = start_q;
  assign inval    = inval_q;
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int HOLD_CYC = 250000,
  parameter int CFG_W    = 8,
  parameter int TRI_BIT  = 0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             pwr_good,
  input  logic             warm_req,
  input  logic [CFG_W-1:0] strap_i,
  output logic             bus_rst_o,
  output logic             drive_en_o,
  output logic [CFG_W-1:0] cfg_o,
  output logic             start_o,
  output logic             inval_o
);
  seq_state_e state;
  logic       hold_done;
  logic       release_ev;
  logic       enter_rst_ev;
  logic       in_hold;
  logic       running;

  assign in_hold = (state == SEQ_HOLD);
  assign running = (state == SEQ_RUN);

  rstseq_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk    (clk),
    .arst_n (arst_n),
    .clr    (!in_hold),
    .en     (in_hold),
    .done   (hold_done)
  );

  rstseq_fsm u_fsm (
    .clk          (clk),
    .arst_n       (arst_n),
    .pwr_good     (pwr_good),
    .warm_req     (warm_req),
    .hold_done    (hold_done),
    .state_o      (state),
    .release_ev   (release_ev),
    .enter_rst_ev (enter_rst_ev)
  );

  rstseq_cfg_latch #(.CFG_W(CFG_W)) u_cfg (
    .clk     (clk),
    .arst_n  (arst_n),
    .capture (release_ev),
    .strap   (strap_i),
    .cfg     (cfg_o)
  );

  rstseq_out_stage #(.CFG_W(CFG_W), .TRI_BIT(TRI_BIT)) u_out (
    .clk          (clk),
    .arst_n       (arst_n),
    .running      (running),
    .release_ev   (release_ev),
    .enter_rst_ev (enter_rst_ev),
    .cfg          (cfg_o),
    .drive_en     (drive_en_o),
    .start        (start_o),
    .inval        (inval_o)
  );

  assign bus_rst_o = !running;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
  parameter int CFG_W   = 8,
  parameter int TRI_BIT = 0
) (
  input logic             clk,
  input logic             arst_n,
  input logic             pwr_good,
  input logic             bus_rst_o,
  input logic             drive_en_o,
  input logic [CFG_W-1:0] cfg_o,
  input logic             start_o,
  input logic             inval_o
);
  // R4
  pg_loss_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !pwr_good |=> bus_rst_o);

  // R6
  gate_off_chk: assert property (@(posedge clk) disable iff (!arst_n)
    bus_rst_o |=> !drive_en_o);

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !($past(bus_rst_o) && !bus_rst_o) |-> $stable(cfg_o));

  // R8
  start_width_chk: assert property (@(posedge clk) disable iff (!arst_n)
    start_o |=> !start_o);

  // R8
  start_place_chk: assert property (@(posedge clk) disable iff (!arst_n)
    start_o |-> (!bus_rst_o && !$past(bus_rst_o) && !cfg_o[TRI_BIT] && drive_en_o));

  // R9
  inval_edge_chk: assert property (@(posedge clk) disable iff (!arst_n)
    inval_o |-> (bus_rst_o && !$past(bus_rst_o)));
endmodule

bind rstseq_top rstseq_chk #(.CFG_W(CFG_W), .TRI_BIT(TRI_BIT)) u_chk (
  .clk        (clk),
  .arst_n     (arst_n),
  .pwr_good   (pwr_good),
  .bus_rst_o  (bus_rst_o),
  .drive_en_o (drive_en_o),
  .cfg_o      (cfg_o),
  .start_o    (start_o),
  .inval_o    (inval_o)
);

// File: tb/rstseq_top_bench.sv
module rstseq_top_bench;
  localparam int N  = 5;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic arst_n, pwr_good, warm_req;
  logic [CW-1:0] strap_i;
  logic bus_rst_o, drive_en_o, start_o, inval_o;
  logic [CW-1:0] cfg_o;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  rstseq_top #(.HOLD_CYC(N), .CFG_W(CW), .TRI_BIT(0)) u_rstseq_top (
    .clk(clk), .arst_n(arst_n), .pwr_good(pwr_good), .warm_req(warm_req),
    .strap_i(strap_i), .bus_rst_o(bus_rst_o), .drive_en_o(drive_en_o),
    .cfg_o(cfg_o), .start_o(start_o), .inval_o(inval_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at the first negedge after the edge that starts a hold.
  // Counts hold cycles and invalidate pulses; optionally pokes warm_req.
  task automatic measure(input bit poke, output int len, output int inv);
    len = 0;
    inv = 0;
    while (bus_rst_o && len < 1000) begin
      len++;
      if (inval_o) inv++;
      if (len == 2) check(drive_en_o == 1'b0, "R6 gate low in hold", drive_en_o, 0);
      warm_req = poke && (len == 2);
      @(negedge clk);
    end
    warm_req = 1'b0;
  endtask

  // Called at the first negedge with bus_rst_o low.
  task automatic check_release(input logic [CW-1:0] exp_cfg);
    bit fl;
    fl = exp_cfg[0];
    check(cfg_o == exp_cfg, "R7 capture", cfg_o, exp_cfg);
    check(start_o == 1'b0 && drive_en_o == 1'b0, "R8 no start at release", start_o, 0);
    strap_i = ~exp_cfg;
    @(negedge clk);
    check(start_o == !fl, "R8 start pulse", start_o, !fl);
    check(drive_en_o == !fl, "R6 gate after release", drive_en_o, !fl);
    @(negedge clk);
    check(start_o == 1'b0, "R8 pulse width", start_o, 0);
    check(cfg_o == exp_cfg, "R7 hold", cfg_o, exp_cfg);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int len, inv;
    arst_n = 1'b0;
    pwr_good = 1'b0;
    warm_req = 1'b0;
    strap_i = '0;
    repeat (3) @(negedge clk);
    check(bus_rst_o && !drive_en_o && !start_o && !inval_o && cfg_o == 0,
          "R1 in reset", bus_rst_o, 1);
    arst_n = 1'b1;
    @(negedge clk);
    check(bus_rst_o && !drive_en_o && !start_o && !inval_o && cfg_o == 0,
          "R1 after reset", bus_rst_o, 1);

    // R2: long wait without power-good
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(bus_rst_o == 1'b1, "R2 waiting", bus_rst_o, 1);
    end

    // R3 cold hold
    strap_i = 4'b0110;
    pwr_good = 1'b1;
    @(negedge clk);
    measure(1'b0, len, inv);
    check(len == N, "R3 cold hold length", len, N);
    check(inv == 0, "R9 no inval on cold", inv, 0);
    check_release(4'b0110);

    // R5/R3/R7/R8/R9 warm sweep over all straps
    for (int c = 0; c < (1 << CW); c++) begin
      strap_i = CW'(c);
      warm_req = 1'b1;
      @(negedge clk);
      warm_req = 1'b0;
      measure(c[0], len, inv);
      check(len == N, "R3 R5 warm hold length", len, N);
      check(inv == 1, "R9 inval pulse", inv, 1);
      check_release(CW'(c));
    end

    // R4 power-good dropout at every hold position
    for (int k = 1; k <= N; k++) begin
      strap_i = '0;
      pwr_good = 1'b0;
      @(negedge clk);
      check(bus_rst_o == 1'b1, "R4 loss while running", bus_rst_o, 1);
      pwr_good = 1'b1;
      @(negedge clk);
      for (int j = 1; j < k; j++) @(negedge clk);
      pwr_good = 1'b0;
      @(negedge clk);
      check(bus_rst_o == 1'b1, "R4 loss in hold", bus_rst_o, 1);
      @(negedge clk);
      check(bus_rst_o == 1'b1, "R4 still waiting", bus_rst_o, 1);
      pwr_good = 1'b1;
      @(negedge clk);
      measure(1'b0, len, inv);
      check(len == N, "R4 full restart", len, N);
      check_release('0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule